// File: doc/BRIEF.md
# 48-bit Floating-Point Adder/Subtractor

This block adds or subtracts two floating-point operands held in a nonstandard 48-bit layout. The sign bit is at the top. Below it is an 11-bit unsigned exponent with a bias of 1024. The low 36 bits are a pure fraction in [0,1) with no hidden bit. An operand therefore stands for fraction × 2^(exponent − 1024). Zero is always the all-zero word.

The block has two pipeline stages. The first aligns the operands, then adds or subtracts their magnitudes. The second normalises the result, truncates it and saturates it when needed. Operands enter through a valid/ready handshake, and results leave through another one. It runs at one operation per cycle when the consumer keeps its ready high. The exponent and fraction widths are parameters. The bench uses a reduced configuration so that the whole operand space can be swept.

Top module: `fpx_addsub`

## Requirements
- R1: Word layout: the sign is bit W-1, the exponent is bits W-2 down to FRAC_W, and the fraction is bits FRAC_W-1 down to 0. For same-sign operands the result is the aligned sum of the fractions, with the sign of the operands.
- R2: When `op_sub_i` is 1 the sign of `opb_i` is inverted before the add path; when it is 0 the operation is an add. If the effective signs differ, the smaller aligned magnitude is taken from the larger one, and the result takes the sign of the larger one.
- R3: The fraction of the operand with the smaller exponent is shifted right by the exponent difference, and the bits shifted out are discarded. An operand whose fraction is zero counts as zero, whatever its sign and exponent.
- R4: A nonzero result has fraction bit FRAC_W-1 set. A carry out of the sum shifts the fraction right by one, dropping its LSB, and adds 1 to the exponent. Leading zeros shift the fraction left and take the shift count off the exponent.
- R5: A zero result is encoded as all bits 0. Two zero operands give that encoding with both flags clear.
- R6: When a nonzero operand cancels exactly, or normalisation would take the exponent below 0, the result is all-zero and `unf_o` is 1.
- R7: When the exponent would exceed its all-ones maximum, the result keeps its sign, the exponent and fraction are all ones, and `ovf_o` is 1.
- R8: An operand pair accepted on a rising edge is presented at the output after the second rising edge that follows, counting the accepting edge. One pair can be accepted per cycle. While `out_valid_o` is 1 and `out_ready_i` is 0, the output and the flags hold.
- R9: During reset `out_valid_o` is 0 and `in_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand pair valid |
| in_ready_o | output | 1 | Block can accept a pair |
| op_sub_i | input | 1 | 1 = subtract b from a, 0 = add |
| opa_i | input | 1+EXP_W+FRAC_W | First operand |
| opb_i | input | 1+EXP_W+FRAC_W | Second operand |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Consumer takes the result |
| res_o | output | 1+EXP_W+FRAC_W | Result word |
| ovf_o | output | 1 | Result saturated on exponent overflow |
| unf_o | output | 1 | Result flushed to zero |

## Verification
A pair accepted on a rising edge reaches the output register on the next edge. It is therefore visible from the falling edge after that second edge, and the bench checks this latency directly on an isolated transaction. In the sweeps, expected results go into a queue in acceptance order when a pair is seen accepted. Each one is removed and compared on the falling edge where the output handshake is seen to complete, so the checks follow the real delay even when the consumer stalls. During stalls the bench also checks that the held result does not change from one falling edge to the next.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } fpx_op_e;
endpackage

// File: rtl/fpx_lzc.sv
module fpx_lzc #(
  parameter int W  = 36,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  in_i,
  output logic [CW-1:0] cnt_o
);
  // highest set bit wins: later iterations overwrite
  always_comb begin
    cnt_o = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (in_i[i]) cnt_o = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fpx_align.sv
module fpx_align
  import fpx_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 36,
  localparam int W = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0]      opa_i,
  input  logic [W-1:0]      opb_i,
  input  fpx_op_e           op_i,
  output logic              sign_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic [FRAC_W:0]   mag_o,
  output logic              both_zero_o
);
  logic              sa, sb;
  logic [EXP_W-1:0]  ea, eb;
  logic [FRAC_W-1:0] fa, fb;
  logic              za, zb, a_big;
  logic              s_big, s_sml;
  logic [EXP_W-1:0]  e_big, e_sml, diff;
  logic [FRAC_W-1:0] f_big, f_sml, f_sh;

  assign sa = opa_i[W-1];
  assign sb = opb_i[W-1] ^ (op_i == OP_SUB);
  assign ea = opa_i[W-2:FRAC_W];
  assign eb = opb_i[W-2:FRAC_W];
  assign fa = opa_i[FRAC_W-1:0];
  assign fb = opb_i[FRAC_W-1:0];
  assign za = (fa == '0);
  assign zb = (fb == '0);

  // a zero-fraction operand never wins the exponent compare
  assign a_big = zb || (!za && (ea >= eb));

  assign s_big = a_big ? sa : sb;
  assign s_sml = a_big ? sb : sa;
  assign e_big = a_big ? ea : eb;
  assign e_sml = a_big ? eb : ea;
  assign f_big = a_big ? fa : fb;
  assign f_sml = a_big ? fb : fa;
  assign diff  = e_big - e_sml;
  assign f_sh  = f_sml >> diff;

  always_comb begin
    sign_o = s_big;
    if (s_big == s_sml) begin
      mag_o = {1'b0, f_big} + {1'b0, f_sh};
    end else if (f_big >= f_sh) begin
      mag_o = {1'b0, f_big - f_sh};
    end else begin
      mag_o  = {1'b0, f_sh - f_big};
      sign_o = s_sml;
    end
  end

  assign exp_o       = e_big;
  assign both_zero_o = za && zb;
endmodule

// File: rtl/fpx_norm.sv
module fpx_norm #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 36,
  localparam int W  = 1 + EXP_W + FRAC_W,
  localparam int CW = $clog2(FRAC_W + 1)
) (
  input  logic              sign_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [FRAC_W:0]   mag_i,
  input  logic              both_zero_i,
  output logic [W-1:0]      res_o,
  output logic              ovf_o,
  output logic              unf_o
);
  logic [CW-1:0]     lz;
  logic [EXP_W:0]    exp_ext, lz_ext, exp_inc, exp_dec;
  logic [FRAC_W-1:0] frac_sh;

  fpx_lzc #(.W(FRAC_W)) lzc_i (
    .in_i  (mag_i[FRAC_W-1:0]),
    .cnt_o (lz)
  );

  assign exp_ext = {1'b0, exp_i};
  assign lz_ext  = (EXP_W + 1)'(lz);
  assign exp_inc = exp_ext + 1'b1;
  assign exp_dec = exp_ext - lz_ext;
  assign frac_sh = mag_i[FRAC_W-1:0] << lz;

  always_comb begin
    res_o = '0;
    ovf_o = 1'b0;
    unf_o = 1'b0;
    if (mag_i == '0) begin
      unf_o = !both_zero_i;
    end else if (mag_i[FRAC_W]) begin
      if (exp_inc[EXP_W]) begin
        ovf_o = 1'b1;
        res_o = {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b1}}};
      end else begin
        res_o = {sign_i, exp_inc[EXP_W-1:0], mag_i[FRAC_W:1]};
      end
    end else if (lz_ext > exp_ext) begin
      unf_o = 1'b1;
    end else begin
      res_o = {sign_i, exp_dec[EXP_W-1:0], frac_sh};
    end
  end
endmodule

// File: rtl/fpx_addsub.sv
module fpx_addsub
  import fpx_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 36,
  localparam int W = 1 + EXP_W + FRAC_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic         op_sub_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] res_o,
  output logic         ovf_o,
  output logic         unf_o
);
  logic              al_sign, al_bz;
  logic [EXP_W-1:0]  al_exp;
  logic [FRAC_W:0]   al_mag;

  logic              s1_v, s1_sign, s1_bz;
  logic [EXP_W-1:0]  s1_exp;
  logic [FRAC_W:0]   s1_mag;

  logic [W-1:0]      nm_res;
  logic              nm_ovf, nm_unf;
  logic              out_v, out_adv, s1_rdy;

  fpx_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) align_i (
    .opa_i       (opa_i),
    .opb_i       (opb_i),
    .op_i        (fpx_op_e'(op_sub_i)),
    .sign_o      (al_sign),
    .exp_o       (al_exp),
    .mag_o       (al_mag),
    .both_zero_o (al_bz)
  );

  fpx_norm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) norm_i (
    .sign_i      (s1_sign),
    .exp_i       (s1_exp),
    .mag_i       (s1_mag),
    .both_zero_i (s1_bz),
    .res_o       (nm_res),
    .ovf_o       (nm_ovf),
    .unf_o       (nm_unf)
  );

  assign out_adv    = !out_v || out_ready_i;
  assign s1_rdy     = !s1_v || out_adv;
  assign in_ready_o = s1_rdy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v    <= 1'b0;
      s1_sign <= 1'b0;
      s1_exp  <= '0;
      s1_mag  <= '0;
      s1_bz   <= 1'b0;
    end else if (s1_rdy) begin
      s1_v <= in_valid_i;
      if (in_valid_i) begin
        s1_sign <= al_sign;
        s1_exp  <= al_exp;
        s1_mag  <= al_mag;
        s1_bz   <= al_bz;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_v <= 1'b0;
      res_o <= '0;
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else if (out_adv) begin
      out_v <= s1_v;
      if (s1_v) begin
        res_o <= nm_res;
        ovf_o <= nm_ovf;
        unf_o <= nm_unf;
      end
    end
  end

  assign out_valid_o = out_v;
endmodule

// File: rtl/fpx_addsub_chk.sv
module fpx_addsub_chk #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 36,
  localparam int W = 1 + EXP_W + FRAC_W
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         out_valid_o,
  input logic         out_ready_i,
  input logic [W-1:0] res_o,
  input logic         ovf_o,
  input logic         unf_o
);
  a_r8_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(res_o) && $stable(ovf_o) && $stable(unf_o));

  a_r4_normalized: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && (res_o != '0) |-> res_o[FRAC_W-1]);

  a_r5_zero_form: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && (res_o[FRAC_W-1:0] == '0) |-> (res_o == '0));

  a_r6_unf_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && unf_o |-> (res_o == '0) && !ovf_o);

  a_r7_ovf_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && ovf_o |-> (res_o[W-2:0] == {(W-1){1'b1}}));
endmodule

bind fpx_addsub fpx_addsub_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .res_o       (res_o),
  .ovf_o       (ovf_o),
  .unf_o       (unf_o)
);

// File: tb/fpx_addsub_tb_top.sv
module fpx_addsub_tb_top;
  localparam int EW   = 3;
  localparam int FW   = 4;
  localparam int W    = 1 + EW + FW;
  localparam int EMAX = (1 << EW) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0, in_ready, op_sub = 1'b0;
  logic [W-1:0] opa = '0, opb = '0, res;
  logic         out_valid, out_ready = 1'b1, ovf, unf;

  int checks = 0, errors = 0;
  bit mon_en = 1'b0, stall_mode = 1'b0, done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [W+1:0] exp_q[$];
  string        tag_q[$];
  bit           held_prev = 1'b0;
  logic [W+1:0] held_val;

  always #5 clk = ~clk;

  fpx_addsub #(.EXP_W(EW), .FRAC_W(FW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .op_sub_i(op_sub), .opa_i(opa), .opb_i(opb), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .res_o(res), .ovf_o(ovf), .unf_o(unf)
  );

  // returns {ovf, unf, res}
  function automatic logic [W+1:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic sub, output string tag);
    int fa, fb, ea, eb, fbig, fsml, ebig, esml, sh, vb, vs, tot, m, e;
    bit sa, sb, abig, sbig, ssml, sg;
    sa = a[W-1];  sb = b[W-1] ^ sub;
    ea = int'(a[W-2:FW]);  eb = int'(b[W-2:FW]);
    fa = int'(a[FW-1:0]);  fb = int'(b[FW-1:0]);
    if (fa == 0 && fb == 0) begin tag = "R5"; return '0; end
    abig = (fb == 0) || (fa != 0 && ea >= eb);
    fbig = abig ? fa : fb;  fsml = abig ? fb : fa;
    ebig = abig ? ea : eb;  esml = abig ? eb : ea;
    sbig = abig ? sa : sb;  ssml = abig ? sb : sa;
    sh = ((ebig - esml) >= FW) ? 0 : (fsml >> (ebig - esml));
    vb = sbig ? -fbig : fbig;
    vs = ssml ? -sh : sh;
    tot = vb + vs;
    sg = tot < 0;
    m = sg ? -tot : tot;
    if (m == 0) begin tag = "R6"; return {1'b0, 1'b1, {W{1'b0}}}; end
    e = ebig;
    while (m >= (1 << FW)) begin m = m >> 1; e++; end
    while (m < (1 << (FW - 1))) begin m = m << 1; e--; end
    if (e > EMAX) begin tag = "R7"; return {1'b1, 1'b0, sg, {(W-1){1'b1}}}; end
    if (e < 0) begin tag = "R6"; return {1'b0, 1'b1, {W{1'b0}}}; end
    if (sub) tag = "R2";
    else if (e != ebig) tag = "R4";
    else if (ea != eb) tag = "R3";
    else tag = "R1";
    return {2'b00, sg, EW'(e), FW'(m)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [W+1:0] act, input logic [W+1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic send(input logic [W-1:0] a, input logic [W-1:0] b, input logic sub);
    string t;
    logic [W+1:0] x;
    in_valid = 1'b1; opa = a; opb = b; op_sub = sub;
    while (!in_ready) @(negedge clk);
    x = model(a, b, sub, t);
    exp_q.push_back(x);
    tag_q.push_back(t);
    @(negedge clk);
  endtask

  // consumer ready changes just after the rising edge
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = stall_mode ? lfsr[0] : 1'b1;
  end

  always @(negedge clk) begin
    if (mon_en) begin
      if (held_prev)
        chk({ovf, unf, res} == held_val && out_valid, "R8 hold", {ovf, unf, res}, held_val);
      held_prev = out_valid && !out_ready;
      held_val  = {ovf, unf, res};
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 unexpected output", {ovf, unf, res}, '0);
        end else begin
          logic [W+1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({ovf, unf, res} == e, t, {ovf, unf, res}, e);
        end
      end
    end
  end

  initial begin
    string t;
    logic [W+1:0] x;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R9 out_valid", {9'b0, out_valid}, '0);
    chk(in_ready == 1'b1, "R9 in_ready", {9'b0, in_ready}, 10'd1);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 latency on an isolated pair: 0_100_1000 + 0_100_1000 -> carry
    in_valid = 1'b1; opa = 8'h48; opb = 8'h48; op_sub = 1'b0;
    x = model(8'h48, 8'h48, 1'b0, t);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b0, "R8 latency early", {9'b0, out_valid}, '0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R8 latency due", {9'b0, out_valid}, 10'd1);
    chk({ovf, unf, res} == x && x == 10'h058, "R4 carry", {ovf, unf, res}, 10'h058);
    @(negedge clk);
    mon_en = 1'b1;
    // exhaustive sweep, both operations
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b++)
          send(W'(a), W'(b), s[0]);
    // back-pressure segment
    stall_mode = 1'b1;
    for (int k = 0; k < 400; k++) send(lfsr[7:0], lfsr[15:8] ^ W'(k), lfsr[3]);
    in_valid = 1'b0;
    stall_mode = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 180000) begin @(posedge clk); cyc++; end
    if (!done) chk(1'b0, "R8 watchdog", '0, '1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule